// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block turns stereo sample pairs into a three-wire serial audio stream: a bit clock, a word clock and one data line. A new left/right pair is taken over a valid/ready handshake once per frame. If no pair is offered at that moment, the frame carries zeros and a sticky flag is raised. An 8-bit control word selects the stream format: which channel goes with which word-clock level, whether the data is delayed by one bit, how the sample sits in its slot, 32 or 64 bit clocks per frame, bit order, sample width, stereo or frame-sync framing, and whether the block drives the clocks (master) or follows external ones (slave).

In master mode the bit clock toggles on each cycle in which the system-clock enable `clk_en` is high. In slave mode `bclk_i` and `ws_i` pass through two-flop synchronisers, and the frame position restarts whenever the word clock enters its left-channel level. Data always changes after a falling bit-clock edge. A control word written while `run` is high is stored and takes effect only once `run` is low.

The controller has three states. `ST_STOP` is idle with the outputs quiet. `ST_ALIGN` is where a slave waits for its first frame start. `ST_SEND` shifts the data out. The transitions are:
- STOP to SEND when `run` rises in master mode.
- STOP to ALIGN when `run` rises in slave mode.
- ALIGN to SEND on the first detected frame start.
- ALIGN or SEND back to STOP whenever `run` is low.

Top module: `aud_tx_top`

## Requirements
- R1: The control word fields are: bit0 polarity, bit1 no-delay, bit2 right-justify, bit3 64-clock frame, bit4 LSB-first, bit5 frame-sync, bit6 24-bit width, bit7 master. A pulse on `cfg_wr` stores the word. The stored word becomes the active format only while `run` is low, so the format never changes while running.
- R2: In stereo mode with polarity 0, the left sample goes out while the word clock is low and the right sample while it is high. With polarity 1 the levels are swapped. The word clock changes at the start of each half frame.
- R3: With no-delay 0, the first data bit of a channel comes one bit clock after the word-clock change. With no-delay 1, it comes in the same bit period as the change.
- R4: With right-justify 1, in master stereo mode, the sample occupies the last bits of its slot. Otherwise it occupies the first bits.
- R5: A frame has 64 bit clocks (32-bit slots) when bit3 is 1, and 32 bit clocks (16-bit slots) when it is 0. A 16-bit sample is taken from input bits [15:0]. A 24-bit sample in 32-clock frames is cut to input bits [23:8].
- R6: Each sample is sent MSB first when bit4 is 0 and LSB first when it is 1.
- R7: In frame-sync mode:
  - The word clock is a high pulse one bit clock wide at each frame start.
  - The left sample is followed at once by the right sample, and the rest of the frame is zero.
  - The programmed polarity and justification have no effect.
- R8: In slave mode, the bit-clock and word-clock output enables are low. The frame follows `bclk_i`/`ws_i`, with the frame starting when `ws_i` enters the left level. Justification is fixed to left-justified.
- R9: `sd_o` changes only when the bit clock falls, and all slot bits outside the sample are 0.
- R10: `in_ready` is high only in the cycle that starts a frame while running. A pair accepted then is sent in that frame.
- R11: A frame start without `in_valid` sends an all-zero pair and sets `underflow`, which stays high until `run` goes low.
- R12: After reset, and one cycle after `run` goes low, `sd_o`, `bclk_o` and `underflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Transmitter enable |
| cfg_wr | input | 1 | Store `cfg_data` as the pending format |
| cfg_data | input | 8 | Format control word (fields in R1) |
| clk_en | input | 1 | Master bit-clock toggle enable |
| in_valid | input | 1 | Sample pair present |
| in_ready | output | 1 | Sample pair taken this cycle |
| in_left | input | 24 | Left sample |
| in_right | input | 24 | Right sample |
| bclk_i | input | 1 | External bit clock (slave) |
| ws_i | input | 1 | External word clock (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| bclk_oe | output | 1 | Bit-clock drive enable |
| ws_o | output | 1 | Generated word clock (master) |
| ws_oe | output | 1 | Word-clock drive enable |
| sd_o | output | 1 | Serial data |
| underflow | output | 1 | Sticky missing-sample flag |

## Verification
The properties assume that `cfg_wr` and `cfg_data` are changed only from the bench's stop/start sequence or as a deliberate mid-run write. They also assume that in slave mode `bclk_i` and `ws_i` move together, with at least several system clocks per bit-clock half period. The bench drives the external clocks at eight system clocks per half period and changes `ws_i` only on the falling edges it generates. It keeps `clk_en` high in master tests, and it checks frames only after the first full frame, so start-up alignment does not enter the checks.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
    localparam int SMP_W    = 24;
    localparam int NARROW_W = 16;
    localparam int SLOT_N   = 16;
    localparam int SLOT_WD  = 32;
    localparam int POS_W    = $clog2(2 * SLOT_WD);
    localparam int CNT_W    = POS_W + 1;

    typedef struct packed {
        logic master;
        logic w24;
        logic fsync;
        logic lsb;
        logic b64;
        logic rj;
        logic nodly;
        logic pol;
    } txcfg_t;

    localparam int CFG_W = $bits(txcfg_t);

    typedef struct packed {
        logic             master;
        logic             fsync;
        logic             lsb;
        logic             dly;
        logic             pol_eff;
        logic             rj_eff;
        logic             trunc;
        logic [CNT_W-1:0] slot;
        logic [CNT_W-1:0] width;
        logic [CNT_W-1:0] frame;
    } fmt_t;

    typedef enum logic [1:0] {ST_STOP, ST_ALIGN, ST_SEND} tx_state_e;
endpackage

// File: rtl/aud_tx_cfg.sv
module aud_tx_cfg
    import aud_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    output txcfg_t           act,
    output fmt_t             fmt
);
    txcfg_t pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            act  <= '0;
        end else begin
            if (cfg_wr) pend <= txcfg_t'(cfg_data);
            if (!run)   act  <= pend;
        end
    end

    always_comb begin
        fmt.master  = act.master;
        fmt.fsync   = act.fsync;
        fmt.lsb     = act.lsb;
        fmt.dly     = !act.nodly;
        fmt.pol_eff = act.pol | act.fsync;
        fmt.rj_eff  = act.rj & act.master & !act.fsync;
        fmt.trunc   = act.w24 & !act.b64;
        fmt.slot    = act.b64 ? CNT_W'(SLOT_WD) : CNT_W'(SLOT_N);
        fmt.width   = (act.w24 && act.b64) ? CNT_W'(SMP_W) : CNT_W'(NARROW_W);
        fmt.frame   = fmt.slot << 1;
    end
endmodule

// File: rtl/aud_tx_edge.sv
module aud_tx_edge
    import aud_tx_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gen_en,
    input  logic master,
    input  logic clk_en,
    input  logic pol_eff,
    input  logic bclk_i,
    input  logic ws_i,
    output logic bclk_q,
    output logic fall_evt,
    output logic ws_edge
);
    logic [SYNC_N:0]   b_sync;
    logic [SYNC_N-1:0] w_sync;
    logic              ws_last;
    logic              fall_s;

    assign fall_s = b_sync[SYNC_N] & ~b_sync[SYNC_N-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_sync  <= '0;
            w_sync  <= '0;
            ws_last <= 1'b0;
            bclk_q  <= 1'b0;
        end else begin
            b_sync <= {b_sync[SYNC_N-1:0], bclk_i};
            w_sync <= {w_sync[SYNC_N-2:0], ws_i};
            if (fall_s) ws_last <= w_sync[SYNC_N-1];
            if (!gen_en)     bclk_q <= 1'b0;
            else if (clk_en) bclk_q <= ~bclk_q;
        end
    end

    assign ws_edge  = !master && fall_s && (w_sync[SYNC_N-1] != ws_last)
                      && (w_sync[SYNC_N-1] == pol_eff);
    assign fall_evt = master ? (gen_en && clk_en && bclk_q) : fall_s;
endmodule

// File: rtl/aud_tx_bitsel.sv
module aud_tx_bitsel
    import aud_tx_pkg::*;
(
    input  logic             fsync,
    input  logic             dly,
    input  logic             rj_eff,
    input  logic             lsb,
    input  logic             trunc,
    input  logic [CNT_W-1:0] slot,
    input  logic [CNT_W-1:0] width,
    input  logic [CNT_W-1:0] frame,
    input  logic [POS_W-1:0] pos,
    input  logic [SMP_W-1:0] left,
    input  logic [SMP_W-1:0] right,
    output logic             bit_o
);
    logic [CNT_W-1:0] p, d, k, idx;
    logic             ch, ok;
    logic [SMP_W-1:0] word, shifted;

    always_comb begin
        p  = CNT_W'(pos);
        d  = dly ? ((p == '0) ? frame - 1'b1 : p - 1'b1) : p;
        ch = 1'b0;
        ok = 1'b1;
        k  = d;
        if (fsync) begin
            if (d >= width && d < (width << 1)) begin
                ch = 1'b1;
                k  = d - width;
            end else if (d >= width) begin
                ok = 1'b0;
            end
        end else begin
            if (d >= slot) begin
                ch = 1'b1;
                k  = d - slot;
            end
            if (rj_eff) begin
                if (k < slot - width) ok = 1'b0;
                else                  k  = k - (slot - width);
            end
        end
        if (k >= width) ok = 1'b0;
        idx = lsb ? k : width - 1'b1 - k;
        if (trunc) idx = idx + CNT_W'(SMP_W - NARROW_W);
        word    = ch ? right : left;
        shifted = word >> idx;
        bit_o   = ok & shifted[0];
    end
endmodule

// File: rtl/aud_tx_top.sv
module aud_tx_top
    import aud_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             clk_en,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SMP_W-1:0] in_left,
    input  logic [SMP_W-1:0] in_right,
    input  logic             bclk_i,
    input  logic             ws_i,
    output logic             bclk_o,
    output logic             bclk_oe,
    output logic             ws_o,
    output logic             ws_oe,
    output logic             sd_o,
    output logic             underflow
);
    tx_state_e        state, state_n;
    txcfg_t           act;
    fmt_t             fmt;
    logic             bclk_q, fall_evt, ws_edge, go, frame_start, gen_en, last;
    logic [POS_W-1:0] pos, pos_n;
    logic [SMP_W-1:0] cur_l, cur_r, new_l, new_r, sel_l, sel_r;
    logic             bit_n, sd_q, ws_q, uflow_q;

    aud_tx_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_wr(cfg_wr),
        .cfg_data(cfg_data), .act(act), .fmt(fmt)
    );

    assign gen_en = run && (state == ST_SEND) && fmt.master;

    aud_tx_edge #(.SYNC_N(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .master(fmt.master),
        .clk_en(clk_en), .pol_eff(fmt.pol_eff), .bclk_i(bclk_i), .ws_i(ws_i),
        .bclk_q(bclk_q), .fall_evt(fall_evt), .ws_edge(ws_edge)
    );

    assign last  = (CNT_W'(pos) == fmt.frame - 1'b1);
    assign pos_n = (last || ws_edge) ? '0 : pos + 1'b1;
    assign go    = run && fall_evt &&
                   (state == ST_SEND || (state == ST_ALIGN && ws_edge));
    assign frame_start = go && (pos_n == '0);
    assign in_ready    = frame_start;

    assign new_l = in_valid ? in_left  : '0;
    assign new_r = in_valid ? in_right : '0;
    assign sel_l = (frame_start && !fmt.dly) ? new_l : cur_l;
    assign sel_r = (frame_start && !fmt.dly) ? new_r : cur_r;

    aud_tx_bitsel u_bits (
        .fsync(fmt.fsync), .dly(fmt.dly), .rj_eff(fmt.rj_eff), .lsb(fmt.lsb),
        .trunc(fmt.trunc), .slot(fmt.slot), .width(fmt.width),
        .frame(fmt.frame), .pos(pos_n), .left(sel_l), .right(sel_r),
        .bit_o(bit_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_STOP:  if (run) state_n = fmt.master ? ST_SEND : ST_ALIGN;
            ST_ALIGN: if (!run) state_n = ST_STOP;
                      else if (fall_evt && ws_edge) state_n = ST_SEND;
            ST_SEND:  if (!run) state_n = ST_STOP;
            default:  state_n = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos     <= '0;
            sd_q    <= 1'b0;
            ws_q    <= 1'b0;
            uflow_q <= 1'b0;
            cur_l   <= '0;
            cur_r   <= '0;
        end else if (!run || state == ST_STOP) begin
            pos  <= POS_W'(fmt.frame - 1'b1);
            sd_q <= 1'b0;
            ws_q <= fmt.fsync ? 1'b0 : !fmt.pol_eff;
            if (!run) uflow_q <= 1'b0;
        end else if (go) begin
            pos  <= pos_n;
            sd_q <= bit_n;
            if (fmt.fsync) ws_q <= (pos_n == '0);
            else           ws_q <= (CNT_W'(pos_n) < fmt.slot) ? fmt.pol_eff : !fmt.pol_eff;
            if (frame_start) begin
                cur_l   <= new_l;
                cur_r   <= new_r;
                uflow_q <= uflow_q | !in_valid;
            end
        end
    end

    assign bclk_o    = fmt.master & bclk_q;
    assign bclk_oe   = fmt.master;
    assign ws_o      = fmt.master & ws_q;
    assign ws_oe     = fmt.master;
    assign sd_o      = sd_q;
    assign underflow = uflow_q;
endmodule

// File: rtl/aud_tx_chk.sv
module aud_tx_chk
    import aud_tx_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   run,
    input logic   in_ready,
    input logic   underflow,
    input logic   sd_o,
    input logic   bclk_o,
    input logic   bclk_oe,
    input logic   ws_o,
    input logic   ws_oe,
    input txcfg_t act
);
    // R12
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!sd_o && !bclk_o && !underflow));

    // R9
    sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && bclk_oe && $past(bclk_oe) && !$stable(sd_o)) |-> $fell(bclk_o));

    // R11
    uflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && underflow) |=> (underflow || !run));

    // R7
    fs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ws_oe && act.fsync && run && $fell(bclk_o) && ws_o) |-> !$past(ws_o));

    // R1
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(act));

    // R10
    ready_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (run && (!bclk_oe || bclk_o)));
endmodule

bind aud_tx_top aud_tx_chk u_chk (.*);

// File: tb/sim_aud_tx_top.sv
`timescale 1ns/1ps
module sim_aud_tx_top;
    logic        clk = 1'b0, rst_n = 1'b0, run = 1'b0, cfg_wr = 1'b0;
    logic [7:0]  cfg_data = '0;
    logic        clk_en = 1'b1, in_valid = 1'b0, in_ready;
    logic [23:0] in_left = '0, in_right = '0;
    logic        bclk_i = 1'b0, ws_i = 1'b0;
    logic        bclk_o, bclk_oe, ws_o, ws_oe, sd_o, underflow;

    int checks = 0, errs = 0, cyc = 0;
    logic cap_sd [0:1023];
    logic cap_ws [0:1023];
    int   cap_n = 0;
    bit   cap_on = 0, slv_on = 0;
    int   s_slot = 32, s_frame = 64, sdiv = 0, spos = 0;
    logic s_L = 1'b0, s_fs = 1'b0;

    localparam logic [23:0] AL = 24'h9A3C71, AR = 24'h5E0B2D;
    localparam logic [23:0] BL = 24'h3C5A96, BR = 24'hC1E47F;

    always #2 clk = ~clk;

    aud_tx_top u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .clk_en(clk_en), .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right), .bclk_i(bclk_i), .ws_i(ws_i),
        .bclk_o(bclk_o), .bclk_oe(bclk_oe), .ws_o(ws_o), .ws_oe(ws_oe),
        .sd_o(sd_o), .underflow(underflow)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run still busy (actual %0d cycles, expected done)", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    // external clock source for slave tests
    always @(negedge clk) begin
        int np;
        if (slv_on) begin
            if (sdiv == 7) begin
                sdiv <= 0;
                if (bclk_i) begin
                    bclk_i <= 1'b0;
                    np = (spos == s_frame - 1) ? 0 : spos + 1;
                    spos <= np;
                    ws_i <= s_fs ? (np == 0) : ((np < s_slot) ? s_L : !s_L);
                end else begin
                    bclk_i <= 1'b1;
                end
            end else begin
                sdiv <= sdiv + 1;
            end
        end
    end

    // capture data and word clock on each rising bit clock
    logic obs, obs_q = 1'b0;
    always @(negedge clk) begin
        obs = slv_on ? bclk_i : bclk_o;
        if (cap_on && obs && !obs_q && cap_n < 1024) begin
            cap_sd[cap_n] = sd_o;
            cap_ws[cap_n] = slv_on ? ws_i : ws_o;
            cap_n++;
        end
        obs_q = obs;
    end

    task automatic ck(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    function automatic logic exp_bit(logic [7:0] c, logic [23:0] l, logic [23:0] r, int d);
        int slot = c[3] ? 32 : 16;
        int w = (c[6] && c[3]) ? 24 : 16;
        bit rj = c[2] && c[7] && !c[5];
        int k, idx;
        logic [23:0] s;
        if (c[5]) begin
            if (d < w) begin s = l; k = d; end
            else if (d < 2 * w) begin s = r; k = d - w; end
            else return 1'b0;
        end else begin
            s = (d < slot) ? l : r;
            k = d % slot;
            if (rj) k = k - (slot - w);
            if (k < 0 || k >= w) return 1'b0;
        end
        idx = c[4] ? k : w - 1 - k;
        if (c[6] && !c[3]) idx += 8;
        return s[idx];
    endfunction

    task automatic set_pair(input logic v, input logic [23:0] l, input logic [23:0] r);
        in_valid = v;
        in_left  = l;
        in_right = r;
    endtask

    task automatic start_tx(input logic [7:0] c);
        @(negedge clk);
        cfg_data = c;
        cfg_wr   = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (3) @(negedge clk);
        run = 1'b1;
    endtask

    task automatic stop_tx();
        @(negedge clk);
        run = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic capture(input int n);
        cap_n  = 0;
        cap_on = 1;
        while (cap_n < n) @(negedge clk);
        cap_on = 0;
    endtask

    task automatic check_frame(input string dtag, input string wtag, input logic [7:0] c,
                               input logic [23:0] l, input logic [23:0] r, input int nth);
        int F = c[3] ? 64 : 32;
        int slot = F / 2;
        logic L = c[5] | c[0];
        int off = c[1] ? 0 : 1;
        int s = -1, seen = 0, bad_d = 0, bad_w = 0;
        for (int i = 1; i < cap_n; i++) begin
            if (s < 0 && cap_ws[i] == L && cap_ws[i-1] != L) begin
                seen++;
                if (seen == nth) s = i;
            end
        end
        if (s < 0 || s + off + F > cap_n) begin
            bad_d = 999;
            bad_w = 999;
        end else begin
            for (int d = 0; d < F; d++)
                if (cap_sd[s + off + d] !== exp_bit(c, l, r, d)) bad_d++;
            for (int p = 0; p < F; p++)
                if (cap_ws[s + p] !== (c[5] ? (p == 0) : ((p < slot) ? L : !L))) bad_w++;
        end
        ck(dtag, bad_d, 0);
        ck(wtag, bad_w, 0);
    endtask

    // R2 R3 R5 R9: standard stereo, 24-bit, 64 clocks, MSB first, delayed
    task automatic t_standard();
        set_pair(1'b1, AL, AR);
        start_tx(8'hC8);
        capture(256);
        check_frame("R3/R5/R9 data 24b 64fs delayed", "R2 ws low=left", 8'hC8, AL, AR, 2);
        stop_tx();
    endtask

    // R4 R6 R10: polarity 1, no delay, right-justified 16-bit LSB first, pair change
    task automatic t_rjust_lsb();
        set_pair(1'b1, AL, AR);
        start_tx(8'h9F);
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        @(negedge clk);
        set_pair(1'b1, BL, BR);
        capture(256);
        check_frame("R4/R6/R10 rjust lsb new pair", "R2 ws high=left", 8'h9F, BL, BR, 1);
        stop_tx();
    endtask

    // R5: 24-bit in 32-clock frame truncated, rjust has no room to act
    task automatic t_trunc();
        set_pair(1'b1, AL, AR);
        start_tx(8'hC4);
        capture(128);
        check_frame("R5 32fs truncation", "R5 ws 16 slot", 8'hC4, AL, AR, 2);
        stop_tx();
    endtask

    // R7: frame-sync with polarity 0 and rjust programmed (both overridden)
    task automatic t_fsync();
        set_pair(1'b1, AL, AR);
        start_tx(8'hEC);
        capture(256);
        check_frame("R7 fsync back-to-back", "R7 fsync pulse", 8'hEC, AL, AR, 2);
        stop_tx();
    endtask

    // R8: slave with rjust programmed (ignored)
    task automatic t_slave();
        set_pair(1'b1, BL, BR);
        s_slot = 32; s_frame = 64; s_L = 1'b0; s_fs = 1'b0;
        spos = 63; sdiv = 0; bclk_i = 1'b0; ws_i = 1'b1;
        slv_on = 1;
        start_tx(8'h4C);
        capture(320);
        ck("R8 slave output enables", {bclk_oe, ws_oe}, 0);
        check_frame("R8 slave data left-justified", "R8 slave ws follows", 8'h4C, BL, BR, 2);
        stop_tx();
        slv_on = 0;
        bclk_i = 1'b0;
    endtask

    // R1: write during run is held until stop
    task automatic t_cfg_hold();
        set_pair(1'b1, AL, AR);
        start_tx(8'hC8);
        @(negedge clk);
        cfg_data = 8'hD8;
        cfg_wr   = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        capture(256);
        check_frame("R1 old format kept while running", "R1 ws old", 8'hC8, AL, AR, 2);
        stop_tx();
        run = 1'b1;
        capture(256);
        check_frame("R1 new format after stop", "R1 ws new", 8'hD8, AL, AR, 2);
        stop_tx();
    endtask

    // R11 R12: underflow zeros, sticky flag, cleared by stop
    task automatic t_underflow();
        int ones = 0;
        set_pair(1'b0, AL, AR);
        start_tx(8'hC8);
        capture(200);
        for (int i = 0; i < cap_n; i++) if (cap_sd[i]) ones++;
        ck("R11 underflow sends zeros", ones, 0);
        ck("R11 underflow flag set", underflow, 1);
        set_pair(1'b1, AL, AR);
        repeat (300) @(negedge clk);
        ck("R11 flag stays while running", underflow, 1);
        stop_tx();
        ck("R12 stop clears outputs", {underflow, sd_o, bclk_o}, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ck("R12 reset outputs", {sd_o, bclk_o, underflow}, 0);
        ck("R10 no ready when stopped", in_ready, 0);
        t_standard();
        t_rjust_lsb();
        t_trunc();
        t_fsync();
        t_slave();
        t_cfg_hold();
        t_underflow();
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule